// File: doc/BRIEF.md
# Three-Channel Aligned PWM Generator

The block drives three pulse-width modulated lines from one shared period counter, so every channel runs at the same frequency and in the same phase. A build-time parameter sets the counter's alignment. In the leading-edge variant the counter counts up. In the trailing-edge variant it counts down. In the centred variant it counts up and then back down, which places each pulse symmetrically about the middle of the period. Each channel compares the counter against its own duty value to decide whether its line is high.

The counter only advances on clock cycles where the `tick` input is high. The rate of `tick` therefore sets the PWM frequency. At a 200 MHz clock and 50 kHz PWM, for example, the parent logic supplies one tick per 2^SIZE-th part of 20 us. The duty inputs may change at any time. Each channel copies its input into a held duty register only on the tick that ends a period, so a period in progress is never cut short or stretched. Two flags are also provided. `sync_o` marks the count the pulses are aligned to. `eop_o` marks the last count of the period. Both flags, and all three PWM lines, come straight from flip-flops.

Top module: `pwm3_aligned`

## Requirements
In this section, MAX denotes 2^SIZE-1. A "step" is one clock cycle with `tick` high. SIZE must be at least 2. ALIGN takes one of three values: ALIGN_FRONT=0, ALIGN_BACK=1 or ALIGN_CENTER=2.
- R1: With ALIGN_FRONT, the counter starts at 0 after reset. It rises by one per step and wraps from MAX to 0, so a period is 2^SIZE steps. Line i is high exactly while count < held duty i.
- R2: With ALIGN_BACK, the counter starts at MAX after reset. It falls by one per step and wraps from 0 to MAX. Line i is high exactly while count < held duty i, so each pulse ends with the period.
- R3: With ALIGN_CENTER, the counter runs 0, 1, ..., MAX, MAX-1, ..., 1 and then repeats from 0, so a period is 2*MAX steps. Line i is high exactly while count > MAX - held duty i, so the pulse is centred on the count MAX.
- R4: Held duty i takes the value of its duty input only on a step made while `eop_o` is high. A change to a duty input at any other time has no effect on the lines until the period after the next end-of-period step.
- R5: `eop_o` is high exactly while the counter is at the last count of its period. That count is MAX for ALIGN_FRONT, 0 for ALIGN_BACK, and 1 on the falling half for ALIGN_CENTER.
- R6: `sync_o` is high exactly while the counter is at the alignment count. That count is 0 for ALIGN_FRONT and ALIGN_BACK, and MAX for ALIGN_CENTER.
- R7: On a clock cycle with `tick` low, the counter, the held duties, the lines and both flags all keep their values.
- R8: A held duty of 0 keeps the line low for the whole period. A held duty of MAX gives MAX high steps out of 2^SIZE for ALIGN_FRONT and ALIGN_BACK, and 2*MAX-1 high steps out of 2*MAX for ALIGN_CENTER.
- R9: When `rst_n` goes low, the block is reset at once, without waiting for a clock edge. The counter goes to its start count, all held duties go to 0, and all lines go low. The release of `rst_n` takes effect on the second rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| tick | input | 1 | Counter step enable; its rate sets the PWM frequency |
| duty0_i | input | SIZE | Requested duty of channel 0 |
| duty1_i | input | SIZE | Requested duty of channel 1 |
| duty2_i | input | SIZE | Requested duty of channel 2 |
| pwm_o | output | 3 | PWM lines; bit i belongs to channel i |
| sync_o | output | 1 | High at the alignment count |
| eop_o | output | 1 | High at the last count of the period |

## Verification
The hardest case to reach from the ports is a duty input that changes in the middle of a period, or while `tick` is low. The correct result is that nothing visible happens until the next end-of-period step. The stimulus table therefore changes all three duty inputs at points that fall outside period boundaries. It also runs the counter with a sparse tick pattern and with no tick at all. A bench model, which latches duty values only at end-of-period steps, then detects any output that reacts too early. Three instances, one per alignment, receive the same inputs, so one stimulus sequence covers all three counter variants.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic [1:0] {
    ALIGN_FRONT  = 2'd0,
    ALIGN_BACK   = 2'd1,
    ALIGN_CENTER = 2'd2
  } align_e;

  localparam int unsigned PWM3_NCH = 3;

endpackage

// File: rtl/pwm3_rst_sync.sv
module pwm3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/pwm3_period_counter.sv
module pwm3_period_counter
  import pwm3_pkg::*;
#(
  parameter int     WIDTH = 5,
  parameter align_e ALIGN = ALIGN_FRONT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [WIDTH-1:0] cnt_nxt,
  output logic             sync_q,
  output logic             eop_q
);

  localparam logic [WIDTH-1:0] CNT_MAX   = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_ZERO  = {WIDTH{1'b0}};
  localparam logic [WIDTH-1:0] CNT_ONE   = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] CNT_START = (ALIGN == ALIGN_BACK) ? CNT_MAX : CNT_ZERO;
  localparam logic             SYNC_RST  = (ALIGN == ALIGN_FRONT);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_adv;
  logic             dir_q;
  logic             dir_adv;
  logic             dir_nxt;
  logic             sync_nxt;
  logic             eop_nxt;

  // Step function and flag decode of the chosen counter variant
  generate
    if (ALIGN == ALIGN_FRONT) begin : g_front
      always_comb begin
        cnt_adv = (cnt_q == CNT_MAX) ? CNT_ZERO : cnt_q + CNT_ONE;
        dir_adv = 1'b0;
      end
      assign sync_nxt = (cnt_nxt == CNT_ZERO);
      assign eop_nxt  = (cnt_nxt == CNT_MAX);
    end else if (ALIGN == ALIGN_BACK) begin : g_back
      always_comb begin
        cnt_adv = (cnt_q == CNT_ZERO) ? CNT_MAX : cnt_q - CNT_ONE;
        dir_adv = 1'b0;
      end
      assign sync_nxt = (cnt_nxt == CNT_ZERO);
      assign eop_nxt  = (cnt_nxt == CNT_ZERO);
    end else begin : g_center
      always_comb begin
        if (!dir_q) begin
          if (cnt_q == CNT_MAX) begin
            cnt_adv = cnt_q - CNT_ONE;
            dir_adv = 1'b1;
          end else begin
            cnt_adv = cnt_q + CNT_ONE;
            dir_adv = 1'b0;
          end
        end else begin
          if (cnt_q == CNT_ONE) begin
            cnt_adv = CNT_ZERO;
            dir_adv = 1'b0;
          end else begin
            cnt_adv = cnt_q - CNT_ONE;
            dir_adv = 1'b1;
          end
        end
      end
      assign sync_nxt = (cnt_nxt == CNT_MAX);
      assign eop_nxt  = dir_nxt && (cnt_nxt == CNT_ONE);
    end
  endgenerate

  // Clock enable: the counter only moves on a tick
  always_comb begin
    if (tick) begin
      cnt_nxt = cnt_adv;
      dir_nxt = dir_adv;
    end else begin
      cnt_nxt = cnt_q;
      dir_nxt = dir_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_START;
      dir_q  <= 1'b0;
      sync_q <= SYNC_RST;
      eop_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      dir_q  <= dir_nxt;
      sync_q <= sync_nxt;
      eop_q  <= eop_nxt;
    end
  end

endmodule

// File: rtl/pwm3_duty_hold.sv
module pwm3_duty_hold #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] duty_in,
  output logic [WIDTH-1:0] duty_nxt,
  output logic [WIDTH-1:0] duty_q
);

  always_comb begin
    if (load) begin
      duty_nxt = duty_in;
    end else begin
      duty_nxt = duty_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else begin
      duty_q <= duty_nxt;
    end
  end

endmodule

// File: rtl/pwm3_compare.sv
module pwm3_compare
  import pwm3_pkg::*;
#(
  parameter int     WIDTH = 5,
  parameter align_e ALIGN = ALIGN_FRONT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic [WIDTH-1:0] duty_nxt,
  output logic             pwm_q
);

  localparam logic [WIDTH:0] SUM_LIMIT = {1'b0, {WIDTH{1'b1}}};

  logic hit;

  generate
    if (ALIGN == ALIGN_CENTER) begin : g_center
      // count > MAX - duty, written without a subtraction that could wrap
      assign hit = ({1'b0, cnt_nxt} + {1'b0, duty_nxt}) > SUM_LIMIT;
    end else begin : g_edge
      assign hit = (cnt_nxt < duty_nxt);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= hit;
    end
  end

endmodule

// File: rtl/pwm3_aligned.sv
module pwm3_aligned
  import pwm3_pkg::*;
#(
  parameter int     SIZE  = 5,
  parameter align_e ALIGN = ALIGN_FRONT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [SIZE-1:0] duty0_i,
  input  logic [SIZE-1:0] duty1_i,
  input  logic [SIZE-1:0] duty2_i,
  output logic [2:0]      pwm_o,
  output logic            sync_o,
  output logic            eop_o
);

  localparam int NCH = PWM3_NCH;

  logic                rst_sync_n;
  logic [SIZE-1:0]     cnt_nxt;
  logic                sync_q;
  logic                eop_q;
  logic                load_duty;
  logic [SIZE-1:0]     duty_in  [NCH];
  logic [SIZE-1:0]     duty_nxt [NCH];
  logic [SIZE-1:0]     duty_q   [NCH];
  logic [NCH*SIZE-1:0] duty_flat;

  pwm3_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  pwm3_period_counter #(
    .WIDTH(SIZE),
    .ALIGN(ALIGN)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .cnt_nxt(cnt_nxt),
    .sync_q (sync_q),
    .eop_q  (eop_q)
  );

  // Duties are taken over only on the step that leaves the last count
  assign load_duty = tick & eop_q;

  assign duty_in[0] = duty0_i;
  assign duty_in[1] = duty1_i;
  assign duty_in[2] = duty2_i;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      pwm3_duty_hold #(
        .WIDTH(SIZE)
      ) u_hold (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .load    (load_duty),
        .duty_in (duty_in[ch]),
        .duty_nxt(duty_nxt[ch]),
        .duty_q  (duty_q[ch])
      );

      pwm3_compare #(
        .WIDTH(SIZE),
        .ALIGN(ALIGN)
      ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .cnt_nxt (cnt_nxt),
        .duty_nxt(duty_nxt[ch]),
        .pwm_q   (pwm_o[ch])
      );

      assign duty_flat[ch*SIZE +: SIZE] = duty_q[ch];
    end
  endgenerate

  assign sync_o = sync_q;
  assign eop_o  = eop_q;

endmodule

// File: rtl/pwm3_aligned_chk.sv
module pwm3_aligned_chk
  import pwm3_pkg::*;
#(
  parameter int     SIZE  = 5,
  parameter align_e ALIGN = ALIGN_FRONT
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [2:0]      pwm,
  input logic            sync,
  input logic            eop,
  input logic [3*SIZE-1:0] held
);

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm) && $stable(sync) && $stable(eop))); // R7

  AST_EOP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eop) |=> !eop); // R5

  AST_SYNC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sync) |=> !sync); // R6

  AST_HELD_ONLY_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && eop) |=> $stable(held)); // R4

  generate
    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (held[ch*SIZE +: SIZE] == '0) |-> !pwm[ch]); // R8

      if (ALIGN == ALIGN_FRONT) begin : g_front
        AST_FRONT_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
          sync |-> (pwm[ch] == (held[ch*SIZE +: SIZE] != '0))); // R1
      end else if (ALIGN == ALIGN_BACK) begin : g_back
        AST_BACK_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
          eop |-> (pwm[ch] == (held[ch*SIZE +: SIZE] != '0))); // R2
      end else begin : g_center
        AST_CENTER_PEAK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
          sync |-> (pwm[ch] == (held[ch*SIZE +: SIZE] != '0))); // R3
      end
    end

    if (ALIGN == ALIGN_FRONT) begin : g_front_wrap
      AST_FRONT_WRAP_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eop) |=> sync); // R6
    end else if (ALIGN == ALIGN_BACK) begin : g_back_end
      AST_BACK_EOP_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> sync); // R6
    end
  endgenerate

endmodule

bind pwm3_aligned pwm3_aligned_chk #(
  .SIZE (SIZE),
  .ALIGN(ALIGN)
) u_chk (
  .clk  (clk),
  .rst_n(rst_sync_n),
  .tick (tick),
  .pwm  (pwm_o),
  .sync (sync_o),
  .eop  (eop_o),
  .held (duty_flat)
);

// File: tb/pwm3_aligned_tb.sv
`timescale 1ns/1ps
module pwm3_aligned_tb;
  import pwm3_pkg::*;

  localparam int SIZE = 3;
  localparam int MAXC = (1 << SIZE) - 1;

  // Vector: [31:24] cycles, [17:16] tick mode (0 every cycle, 1 one in three,
  // 2 none), [11:8] duty2, [7:4] duty1, [3:0] duty0
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h3C00_0000,  // R8 zero duty on all channels
    32'h3C00_0777,  // R8 maximum duty
    32'h3C00_0641,  // R1 R2 R3 mixed duties
    32'h5001_0253,  // R7 sparse tick
    32'h1E02_0706,  // R7 R4 no tick, duty changed
    32'h0500_0162,  // R4 change in mid period
    32'h3C00_0435,
    32'h3C01_0370
  };

  logic            clk;
  logic            rst_n;
  logic            tick;
  logic [SIZE-1:0] duty0, duty1, duty2;
  logic [2:0]      pwm_f, pwm_b, pwm_c;
  logic            sync_f, sync_b, sync_c;
  logic            eop_f, eop_b, eop_c;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  pwm3_aligned #(.SIZE(SIZE), .ALIGN(ALIGN_FRONT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .duty0_i(duty0), .duty1_i(duty1), .duty2_i(duty2),
    .pwm_o(pwm_f), .sync_o(sync_f), .eop_o(eop_f));

  pwm3_aligned #(.SIZE(SIZE), .ALIGN(ALIGN_BACK)) u_dut_back (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .duty0_i(duty0), .duty1_i(duty1), .duty2_i(duty2),
    .pwm_o(pwm_b), .sync_o(sync_b), .eop_o(eop_b));

  pwm3_aligned #(.SIZE(SIZE), .ALIGN(ALIGN_CENTER)) u_dut_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .duty0_i(duty0), .duty1_i(duty1), .duty2_i(duty2),
    .pwm_o(pwm_c), .sync_o(sync_c), .eop_o(eop_c));

  // Bench model built from the requirements
  logic [1:0] rs;
  int mf, mb, mc;
  bit md;
  int sf [3];
  int sb [3];
  int sc [3];
  int dv [3];

  always_comb begin
    dv[0] = int'(duty0);
    dv[1] = int'(duty1);
    dv[2] = int'(duty2);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !rs[1]) begin
      mf <= 0; mb <= MAXC; mc <= 0; md <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        sf[i] <= 0; sb[i] <= 0; sc[i] <= 0;
      end
    end else if (tick) begin
      if (mf == MAXC) for (int i = 0; i < 3; i++) sf[i] <= dv[i];
      mf <= (mf == MAXC) ? 0 : mf + 1;
      if (mb == 0) for (int i = 0; i < 3; i++) sb[i] <= dv[i];
      mb <= (mb == 0) ? MAXC : mb - 1;
      if (md && mc == 1) for (int i = 0; i < 3; i++) sc[i] <= dv[i];
      if (!md) begin
        if (mc == MAXC) begin mc <= MAXC - 1; md <= 1'b1; end
        else mc <= mc + 1;
      end else begin
        if (mc == 1) begin mc <= 0; md <= 1'b0; end
        else mc <= mc - 1;
      end
    end
  end

  function automatic logic [4:0] exp_front();
    logic [4:0] e;
    for (int i = 0; i < 3; i++) e[2+i] = (mf < sf[i]);
    e[1] = (mf == 0);
    e[0] = (mf == MAXC);
    return e;
  endfunction

  function automatic logic [4:0] exp_back();
    logic [4:0] e;
    for (int i = 0; i < 3; i++) e[2+i] = (mb < sb[i]);
    e[1] = (mb == 0);
    e[0] = (mb == 0);
    return e;
  endfunction

  function automatic logic [4:0] exp_center();
    logic [4:0] e;
    for (int i = 0; i < 3; i++) e[2+i] = (mc > MAXC - sc[i]);
    e[1] = (mc == MAXC);
    e[0] = md && (mc == 1);
    return e;
  endfunction

  task automatic check_val(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pwm,sync,eop} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model(input string ctx);
    check_val({"R1 R4 R5 R6 front ", ctx}, {pwm_f, sync_f, eop_f}, exp_front());
    check_val({"R2 R4 R5 R6 back ", ctx}, {pwm_b, sync_b, eop_b}, exp_back());
    check_val({"R3 R4 R5 R6 center ", ctx}, {pwm_c, sync_c, eop_c}, exp_center());
  endtask

  task automatic check_reset_state(input string ctx);
    check_val({"R9 front ", ctx},  {pwm_f, sync_f, eop_f}, 5'b000_1_0);
    check_val({"R9 back ", ctx},   {pwm_b, sync_b, eop_b}, 5'b000_0_0);
    check_val({"R9 center ", ctx}, {pwm_c, sync_c, eop_c}, 5'b000_0_0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual running expected done");
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0;
    duty0 = '0; duty1 = '0; duty2 = '0;
    repeat (3) @(negedge clk);
    check_reset_state("in reset");  // R9
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < int'(VEC[v][31:24]); c++) begin
        @(negedge clk);
        check_model($sformatf("vector %0d cycle %0d", v, c));
        duty0 = VEC[v][2:0];
        duty1 = VEC[v][6:4];
        duty2 = VEC[v][10:8];
        case (VEC[v][17:16])
          2'd0:    tick = 1'b1;
          2'd1:    tick = ((c % 3) == 0);
          default: tick = 1'b0;
        endcase
      end
    end

    // R9: reset taken without a clock edge, in the middle of a period
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("asynchronous assert");
    @(negedge clk);
    rst_n = 1'b1;
    tick = 1'b1;
    duty0 = 3'd4; duty1 = 3'd7; duty2 = 3'd1;
    // R9: release lands on the second rising edge; counters still at start
    @(negedge clk);
    check_reset_state("one edge after release");
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      check_model($sformatf("after reset cycle %0d", c));
    end

    // R8: count high steps with maximum duty held over a full period
    begin
      int hf, hc;
      duty0 = 3'd7;
      repeat (30) @(negedge clk);
      while (!eop_c) @(negedge clk);
      hf = 0; hc = 0;
      for (int c = 0; c < 2 * MAXC; c++) begin
        @(negedge clk);
        hc += int'(pwm_c[0]);
      end
      while (!eop_f) @(negedge clk);
      for (int c = 0; c < MAXC + 1; c++) begin
        @(negedge clk);
        hf += int'(pwm_f[0]);
      end
      check_val("R8 front high steps", 5'(hf), 5'(MAXC));
      check_val("R8 center high steps", 5'(hc), 5'(2 * MAXC - 1));
    end

    done = 1'b1;
    finish_run();
  end

endmodule